// File: doc/BRIEF.md
# Burst Stereo Serial Transmitter

This block turns parallel stereo samples into two serial streams, one pin per channel. Both streams are driven in the same bit periods. It makes its own bit clock and word clock. The word clock runs at eight times the input sample rate, and each period of the word clock is one word slot. Within each slot the bit clock only pulses for the selected word length, 18 or 20 bits. It stays low for the rest of the slot. The slot length is fixed by a rate select: 24 or 32 bit periods.

Samples are 20-bit two's complement values. An upstream filter delivers them through a valid/ready handshake into a single holding register. At every slot boundary the transmitter takes the held pair, or silence when the register is empty. It also takes a fresh copy of the width and rate selects at that boundary. All serial outputs are registered on the falling edge of the system clock, so a receiver clocked on the rising bit-clock edge sees settled data.

Top module: `burst_stereo_tx`

## Requirements
- R1: Bit period n of a slot (n = 0 first) carries bit 19-n of the left sample on `ser_left` and of the right sample on `ser_right`, in the same bit period, most significant bit first. Outside the active bits both data outputs are 0.
- R2: With `short_word` = 1 a slot carries 18 bits, which are sample bits 19..2, so the two least significant bits are truncated. With `short_word` = 0 it carries all 20 bits.
- R3: `ser_bck` gives exactly one high pulse per active bit, 18 or 20 per slot, and stays low for every remaining bit period of the slot.
- R4: A bit period is 2×HALF_CLKS system clocks: low for the first HALF_CLKS, high for the second. A slot is 24 bit periods with `fast_rate` = 1 and 32 with `fast_rate` = 0.
- R5: `ser_wck` is high for the first half of every slot (bit periods 0 to slot/2-1) and low for the second half. Its rising edge marks the slot boundary, at which the previous word is complete.
- R6: Serial outputs change only on the falling system-clock edge. Data holds steady while `ser_bck` is high, so it changes only together with a falling or idle bit clock.
- R7: `in_ready` is high when the holding register is empty, or during the last system clock of a slot. A pair accepted in that last clock is not sent in the slot that begins next. That slot carries the previously held pair, and the new pair is sent in the slot after.
- R8: If the holding register is empty at a slot boundary, the whole next slot carries zeros on both data outputs. Its bit-clock pulses are still produced.
- R9: `short_word` and `fast_rate` are sampled only at the slot boundary. A change in the middle of a slot affects the following slot.
- R10: While `rst` is high all serial outputs are 0 and the holding register is empty. The first rising clock edge with `rst` low starts a slot, so `ser_wck` is high after the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding register can take a pair this cycle |
| in_left | input | 20 | Left sample, two's complement |
| in_right | input | 20 | Right sample, two's complement |
| short_word | input | 1 | 1: 18-bit words, 0: 20-bit words |
| fast_rate | input | 1 | 1: 24-bit-period slots, 0: 32-bit-period slots |
| ser_bck | output | 1 | Burst bit clock |
| ser_wck | output | 1 | Word clock, one period per slot |
| ser_left | output | 1 | Left serial data |
| ser_right | output | 1 | Right serial data |

## Verification
Two things can land on the same clock: the slot boundary draining the holding register, and the upstream handshake refilling it. One sweep keeps the register full and offers a pair only in the last clock of each slot, so every acceptance lands on a drain. The outcome is judged against the word order in later slots. The held pair must go out first, and the new one one slot later. The number of such coincidences is also checked to be non-zero. The same cycle model is also driven with continuous offers, with sparse offers that cause silent slots, and with width/rate changes in the middle of a slot.

// File: rtl/bst_pkg.sv
package bst_pkg;

  localparam int NUM_LANES = 2;

  typedef struct packed {
    logic short_w;
    logic fast_rate;
  } slot_cfg_t;

endpackage

// File: rtl/bst_slot_timer.sv
module bst_slot_timer
  import bst_pkg::*;
#(
  parameter int HALF_CLKS  = 1,
  parameter int SAMPLE_W   = 20,
  parameter int SHORT_W    = 18,
  parameter int SLOT_SHORT = 24,
  parameter int SLOT_LONG  = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  slot_cfg_t cfg_in,
  output logic      slot_wrap,
  output logic      shift_en,
  output logic      active,
  output logic      bck_nx,
  output logic      wck_nx
);

  localparam int DIV = 2 * HALF_CLKS;
  localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW  = $clog2(SLOT_LONG + 1);

  localparam logic [PW-1:0] PH_LAST  = PW'(DIV - 1);
  localparam logic [PW-1:0] PH_HIGH  = PW'(HALF_CLKS);
  localparam logic [BW-1:0] LAST_S   = BW'(SLOT_SHORT - 1);
  localparam logic [BW-1:0] LAST_L   = BW'(SLOT_LONG - 1);
  localparam logic [BW-1:0] MID_S    = BW'(SLOT_SHORT / 2);
  localparam logic [BW-1:0] MID_L    = BW'(SLOT_LONG / 2);
  localparam logic [BW-1:0] BITS_S   = BW'(SHORT_W);
  localparam logic [BW-1:0] BITS_L   = BW'(SAMPLE_W);

  logic [PW-1:0] phase;
  logic [BW-1:0] bit_idx;
  slot_cfg_t     cfg;

  logic [BW-1:0] last_bit;
  logic [BW-1:0] mid_bit;
  logic [BW-1:0] word_bits;
  logic          end_of_bit;

  always_comb begin
    last_bit   = cfg.fast_rate ? LAST_S : LAST_L;
    mid_bit    = cfg.fast_rate ? MID_S : MID_L;
    word_bits  = cfg.short_w ? BITS_S : BITS_L;
    end_of_bit = (phase == PH_LAST);
    slot_wrap  = end_of_bit && (bit_idx == last_bit);
    shift_en   = end_of_bit && !slot_wrap;
    active     = (bit_idx < word_bits);
    bck_nx     = active && (phase >= PH_HIGH);
    wck_nx     = (bit_idx < mid_bit);
  end

  // Reset parks the counters on the last clock of a long slot so that
  // the first clock out of reset is a slot boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_LAST;
      bit_idx <= LAST_L;
      cfg     <= '0;
    end else if (slot_wrap) begin
      phase   <= '0;
      bit_idx <= '0;
      cfg     <= cfg_in;
    end else if (end_of_bit) begin
      phase   <= '0;
      bit_idx <= bit_idx + 1'b1;
    end else begin
      phase   <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/bst_hold_buf.sv
module bst_hold_buf #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_right,
  input  logic         take,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right
);

  logic         full;
  logic [W-1:0] hold_l;
  logic [W-1:0] hold_r;
  logic         accept;

  assign in_ready  = !full || take;
  assign accept    = in_valid && in_ready;
  assign out_left  = full ? hold_l : '0;
  assign out_right = full ? hold_r : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (accept) begin
      full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      hold_l <= in_left;
      hold_r <= in_right;
    end
  end

endmodule

// File: rtl/bst_lane.sv
module bst_lane #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  output logic         msb
);

  logic [W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
    end else if (load) begin
      sreg <= load_word;
    end else if (shift) begin
      sreg <= {sreg[W-2:0], 1'b0};
    end
  end

  assign msb = sreg[W-1];

endmodule

// File: rtl/burst_stereo_tx.sv
module burst_stereo_tx
  import bst_pkg::*;
#(
  parameter int HALF_CLKS  = 1,
  parameter int SAMPLE_W   = 20,
  parameter int SHORT_W    = 18,
  parameter int SLOT_SHORT = 24,
  parameter int SLOT_LONG  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                short_word,
  input  logic                fast_rate,
  output logic                ser_bck,
  output logic                ser_wck,
  output logic                ser_left,
  output logic                ser_right
);

  slot_cfg_t cfg_in;
  logic      slot_wrap;
  logic      shift_en;
  logic      active;
  logic      bck_nx;
  logic      wck_nx;

  logic [SAMPLE_W-1:0]  take_l;
  logic [SAMPLE_W-1:0]  take_r;
  logic [SAMPLE_W-1:0]  lane_word [NUM_LANES];
  logic [NUM_LANES-1:0] lane_msb;

  assign cfg_in.short_w   = short_word;
  assign cfg_in.fast_rate = fast_rate;

  bst_slot_timer #(
    .HALF_CLKS (HALF_CLKS),
    .SAMPLE_W  (SAMPLE_W),
    .SHORT_W   (SHORT_W),
    .SLOT_SHORT(SLOT_SHORT),
    .SLOT_LONG (SLOT_LONG)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .cfg_in   (cfg_in),
    .slot_wrap(slot_wrap),
    .shift_en (shift_en),
    .active   (active),
    .bck_nx   (bck_nx),
    .wck_nx   (wck_nx)
  );

  bst_hold_buf #(.W(SAMPLE_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_left  (in_left),
    .in_right (in_right),
    .take     (slot_wrap),
    .out_left (take_l),
    .out_right(take_r)
  );

  assign lane_word[0] = take_l;
  assign lane_word[1] = take_r;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    bst_lane #(.W(SAMPLE_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .load     (slot_wrap),
      .load_word(lane_word[g]),
      .shift    (shift_en),
      .msb      (lane_msb[g])
    );
  end

  // Output stage on the falling system-clock edge: the bit clock falls
  // and new data appears together, half a clock after the state moves.
  always_ff @(negedge clk) begin
    if (rst) begin
      ser_bck   <= 1'b0;
      ser_wck   <= 1'b0;
      ser_left  <= 1'b0;
      ser_right <= 1'b0;
    end else begin
      ser_bck   <= bck_nx;
      ser_wck   <= wck_nx;
      ser_left  <= active && lane_msb[0];
      ser_right <= active && lane_msb[1];
    end
  end

endmodule

// File: rtl/burst_stereo_tx_chk.sv
module burst_stereo_tx_chk #(
  parameter int HALF_CLKS  = 1,
  parameter int SAMPLE_W   = 20,
  parameter int SHORT_W    = 18,
  parameter int SLOT_SHORT = 24,
  parameter int SLOT_LONG  = 32
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic slot_wrap,
  input logic ser_bck,
  input logic ser_wck,
  input logic ser_left,
  input logic ser_right
);

  localparam int LEN_S = 2 * HALF_CLKS * SLOT_SHORT;
  localparam int LEN_L = 2 * HALF_CLKS * SLOT_LONG;

  int   clk_cnt;
  int   rise_cnt;
  logic seen;
  logic bck_d;
  logic wck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_cnt  <= 0;
      rise_cnt <= 0;
      seen     <= 1'b0;
      bck_d    <= 1'b0;
      wck_d    <= 1'b0;
    end else begin
      bck_d <= ser_bck;
      wck_d <= ser_wck;
      if (ser_wck && !wck_d) begin
        clk_cnt  <= 1;
        rise_cnt <= 0;
        seen     <= 1'b1;
      end else begin
        clk_cnt <= clk_cnt + 1;
        if (ser_bck && !bck_d) rise_cnt <= rise_cnt + 1;
      end
    end
  end

  assert_data_steady_R6: assert property (@(posedge clk) disable iff (rst)
    ser_bck |-> ($stable(ser_left) && $stable(ser_right)));

  assert_wck_rise_bck_low_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_wck) |-> !ser_bck);

  assert_slot_length_R4: assert property (@(posedge clk) disable iff (rst)
    (ser_wck && !wck_d && seen) |-> (clk_cnt == LEN_S || clk_cnt == LEN_L));

  assert_pulse_count_R3: assert property (@(posedge clk) disable iff (rst)
    (ser_wck && !wck_d && seen) |-> (rise_cnt == SHORT_W || rise_cnt == SAMPLE_W));

  assert_ready_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!in_ready || slot_wrap));

endmodule

bind burst_stereo_tx burst_stereo_tx_chk #(
  .HALF_CLKS (HALF_CLKS),
  .SAMPLE_W  (SAMPLE_W),
  .SHORT_W   (SHORT_W),
  .SLOT_SHORT(SLOT_SHORT),
  .SLOT_LONG (SLOT_LONG)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .slot_wrap(slot_wrap),
  .ser_bck  (ser_bck),
  .ser_wck  (ser_wck),
  .ser_left (ser_left),
  .ser_right(ser_right)
);

// File: tb/burst_stereo_tx_tb_top.sv
module burst_stereo_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [19:0] in_left = '0;
  logic [19:0] in_right = '0;
  logic        short_word = 1'b0;
  logic        fast_rate = 1'b0;
  logic        ser_bck, ser_wck, ser_left, ser_right;

  always #2 clk = ~clk;

  burst_stereo_tx dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .short_word(short_word),
    .fast_rate(fast_rate), .ser_bck(ser_bck), .ser_wck(ser_wck),
    .ser_left(ser_left), .ser_right(ser_right)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, vmode = 0, word_idx = 0;
  int collisions = 0, underruns = 0;
  logic nx_rst = 1'b1, nx_short = 1'b0, nx_fast = 1'b0;

  // reference model state
  int m_k = 63;
  logic m_short = 0, m_fast = 0, m_full = 0, m_acc = 0, m_under = 0, m_chg = 0;
  logic [19:0] m_pl = '0, m_pr = '0, m_wl = '0, m_wr = '0;
  int prev_len = 0, prev_bits = 0;

  // observation state
  logic [3:0] last4 = '0;
  logic prev_bck = 0, prev_wck = 0, obs_on = 0;
  int obs_cnt = 0, obs_rises = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      if (n_fail <= 30) $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int slot_len(input logic f);
    return f ? 48 : 64;
  endfunction

  task automatic next_word();
    case (word_idx)
      0: begin in_left = 20'h80000; in_right = 20'h7FFFF; end
      1: begin in_left = 20'hFFFFF; in_right = 20'h00001; end
      2: begin in_left = 20'h00003; in_right = 20'hFFFFD; end
      3: begin in_left = 20'hAAAAA; in_right = 20'h55555; end
      default: begin
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        in_left = lfsr[19:0];
        in_right = lfsr[31:12] ^ 20'h5A5A5;
      end
    endcase
    word_idx++;
  endtask

  task automatic model_edge();
    bit wr;
    if (rst) begin
      m_k = 63; m_fast = 0; m_short = 0; m_full = 0; m_wl = '0; m_wr = '0; m_acc = 0;
      return;
    end
    wr = (m_k == slot_len(m_fast) - 1);
    m_acc = in_valid && (!m_full || wr);
    if (wr && m_acc && m_full) collisions++;
    if (wr) begin
      prev_len = slot_len(m_fast);
      prev_bits = m_short ? 18 : 20;
      m_chg = (m_short != short_word) || (m_fast != fast_rate);
      m_k = 0; m_short = short_word; m_fast = fast_rate;
      m_under = !m_full;
      if (!m_full) underruns++;
      m_wl = m_full ? m_pl : '0;
      m_wr = m_full ? m_pr : '0;
      m_full = 0;
    end else begin
      m_k++;
    end
    if (m_acc) begin m_pl = in_left; m_pr = in_right; m_full = 1; end
  endtask

  task automatic sample_and_compare();
    int b, p, w, s;
    bit act, e_bck, e_wck, e_l, e_r;
    string dtag;
    b = m_k / 2; p = m_k % 2;
    w = m_short ? 18 : 20;
    s = m_fast ? 24 : 32;
    act = (b < w);
    e_bck = act && (p == 1);
    e_wck = (b < s / 2);
    e_l = act ? m_wl[19 - b] : 1'b0;
    e_r = act ? m_wr[19 - b] : 1'b0;
    if (rst) begin
      check({ser_bck, ser_wck, ser_left, ser_right} == 4'b0, "R10 outputs low in reset",
            {ser_bck, ser_wck, ser_left, ser_right}, 0);
    end else begin
      dtag = m_under ? "R8 silent slot data" : (m_short ? "R2 short word data" : "R1 serial data");
      check(ser_bck == e_bck, m_chg ? "R9 bit clock after cfg change" : "R3 bit clock", ser_bck, e_bck);
      check(ser_wck == e_wck, "R5 word clock", ser_wck, e_wck);
      check({ser_left, ser_right} == {e_l, e_r}, dtag, {ser_left, ser_right}, {e_l, e_r});
      check(in_ready == (!m_full || m_k == slot_len(m_fast) - 1), "R7 ready",
            in_ready, (!m_full || m_k == slot_len(m_fast) - 1));
      if (ser_wck && !prev_wck) begin
        if (obs_on) begin
          check(obs_cnt == prev_len, "R4 slot length in clocks", obs_cnt, prev_len);
          check(obs_rises == prev_bits, "R3 pulses per slot", obs_rises, prev_bits);
        end
        obs_on = 1; obs_cnt = 1; obs_rises = 0;
      end else begin
        obs_cnt++;
        if (ser_bck && !prev_bck) obs_rises++;
      end
    end
    prev_bck = ser_bck; prev_wck = ser_wck;
    last4 = {ser_bck, ser_wck, ser_left, ser_right};
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #1;
    if (!rst)
      check({ser_bck, ser_wck, ser_left, ser_right} == last4, "R6 no change on rising edge",
            {ser_bck, ser_wck, ser_left, ser_right}, last4);
    if (m_acc) next_word();
    rst = nx_rst;
    short_word = nx_short;
    fast_rate = nx_fast;
    case (vmode)
      0: in_valid = 1'b1;
      1: in_valid = (cyc % 150 == 0);
      default: in_valid = (m_k == slot_len(m_fast) - 1);
    endcase
    if (rst) in_valid = 1'b0;
    cyc++;
    #2;
    sample_and_compare();
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    next_word();
    repeat (4) tick();
    nx_rst = 1'b0;
    repeat (2) tick();
    check(ser_wck == 1'b1 && ser_bck == 1'b0 && ser_left == 1'b0, "R10 first slot after release",
          {ser_wck, ser_bck, ser_left}, 3'b100);
    for (int c = 0; c < 4; c++) begin
      nx_short = c[0];
      nx_fast = c[1];
      for (int md = 0; md < 3; md++) begin
        vmode = md;
        repeat (12 * 64) tick();
      end
    end
    vmode = 0;
    for (int i = 0; i < 30; i++) begin
      nx_short = i[0];
      nx_fast = i[1] ^ i[2];
      repeat (37 + i) tick();
    end
    check(collisions > 0, "R7 drain and refill in one clock observed", collisions, 1);
    check(underruns > 1, "R8 empty holding register at boundary observed", underruns, 2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule